// File: doc/BRIEF.md
# Self-Aligning Sequential Integer Divider

This block divides one unsigned W-bit integer by another over several clock cycles. The number of cycles depends on the operands. The partial remainder stays in a fixed register. The divisor sits in a wide shift register. The divisor is first moved left until one more doubling would make it larger than the remainder. It is then moved back right one place per cycle, and it is subtracted wherever it fits.

One subtractor serves both phases. During alignment it tests the doubled divisor against the remainder in the same cycle that the shift happens. During division it produces the trial difference. The quotient bits enter the low half of the same shift register. They arrive most significant bit first, so the output wiring reverses their order.

No iteration counter is used. A single marker bit is loaded next to the bottom of the register. It travels up with the divisor and back down again. Its arrival in the lowest position ends the operation. A caller pulses `start` with both operands while the block is idle, then waits for the one-cycle `done` pulse. The results stay on the outputs until the next accepted start.

Top module: `sa_divider`

## Requirements
- R1: While `rst` is high, and at the first clock after it falls, `busy` and `done` are 0, and `quotient` and `remainder` are 0.
- R2: For a nonzero divisor, in the cycle where `done` is 1, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. Both operands are unsigned.
- R3: `busy` rises on the clock edge that accepts `start` with a nonzero divisor. It stays 1 until the edge that raises `done`. `done` is a single-cycle pulse, and `busy` is 0 while `done` is 1.
- R4: Let k be the largest integer with divisor·2^k ≤ dividend, or 0 when dividend < divisor. Then `done` rises exactly 2k+2 clock edges after the accepting edge.
- R5: A zero divisor raises `done` on the edge right after the accepting edge. `busy` is never raised for it, `quotient` is all ones and `remainder` equals the dividend.
- R6: A `start` pulse while `busy` is 1 is ignored. The running division completes with its original operands and its original timing.
- R7: While idle with `start` low, `quotient` and `remainder` keep their last values.
- R8: No division takes more than 2W clock edges from the accepting edge to `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; only acted on while idle |
| dividend_i | input | W | Unsigned dividend, sampled with start |
| divisor_i | input | W | Unsigned divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Quotient, least significant bit at index 0 |
| remainder | output | W | Remainder |

## Verification
The bench targets the extremes of alignment depth: divisor 1 with an all-ones dividend, a dividend smaller than the divisor, equal operands, and exact powers of two. If the marker handling or the over-shift test were wrong, these cases would give a latency that is off by one or two edges, or a quotient with a bit dropped or shifted. A zero divisor checks the one-cycle defined result; a design that ran it through the normal loop would never finish or would give garbage. Stray start pulses in the middle of a long division catch a design that reloads its operands while busy. The idle cycles after each result catch outputs that drift.

// File: rtl/sa_divider.sv
module sa_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int SW = 2*W + 2;
  localparam int HI = 2*W;
  localparam int LO = W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ALIGN, S_DIV} state_t;

  state_t        st;
  logic [SW-1:0] sr;
  logic [W-1:0]  rem;
  logic          done_q;

  wire [W:0]   cand = (st == S_ALIGN) ? {sr[HI:LO], 1'b0} : {1'b0, sr[HI:LO]};
  wire [W+1:0] diff = {2'b00, rem} - {1'b0, cand};
  wire         fits = ~diff[W+1];

  wire [SW-1:0] sr_init  = {1'b0, divisor_i, {(W-1){1'b0}}, 1'b1, 1'b0};
  wire [SW-1:0] sr_zero  = {1'b0, {W{1'b0}}, {W{1'b1}}, 1'b0};
  wire [SW-1:0] sr_left  = {sr[SW-2:0], 1'b0};
  wire [SW-1:0] sr_right = {1'b0, sr[SW-1:W+2], fits, sr[W:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      sr     <= '0;
      rem    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rem <= dividend_i;
          if (divisor_i == '0) begin
            sr     <= sr_zero;
            done_q <= 1'b1;
          end else begin
            sr <= sr_init;
            st <= S_ALIGN;
          end
        end
        S_ALIGN: begin
          if (fits) sr <= sr_left;
          else      st <= S_DIV;
        end
        S_DIV: begin
          sr <= sr_right;
          if (fits) rem <= diff[W-1:0];
          if (sr[1]) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign quotient[i] = sr[W-i];
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign remainder = rem;
endmodule

module sa_divider_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   divisor_i,
  input logic           busy,
  input logic           done,
  input logic [W-1:0]   quotient,
  input logic [W-1:0]   remainder,
  input logic [2*W+1:0] sr
);
  localparam int CW = $clog2(2*W) + 2;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_stop_bit_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !sr[2*W+1]);
  assert_rem_never_grows_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> remainder <= $past(remainder));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor_i == '0) |=> (done && !busy && quotient == '1));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
  assert_latency_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_cnt < CW'(2*W));
endmodule

bind sa_divider sa_divider_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .divisor_i(divisor_i),
  .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
  .sr(sr)
);

// File: tb/test_sa_divider.sv
module test_sa_divider;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic busy, done;
  logic [W-1:0] quotient, remainder;

  always #5 clk = ~clk;

  sa_divider #(.W(W)) i_sa_divider (
    .clk(clk), .rst(rst), .start(start),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  int tests = 0;
  int fails = 0;
  string op_tag = "R2";

  logic m_busy = 1'b0, m_done = 1'b0;
  int m_cnt = 0;
  logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
  int dut_lat = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_q <= '0; m_r <= '0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_q <= p_q; m_r <= p_r;
        end else m_cnt <= m_cnt - 1;
      end else if (start) begin
        if (divisor_i == '0) begin
          m_done <= 1'b1; m_q <= '1; m_r <= dividend_i;
        end else begin
          int a, b, v, k;
          a = int'(dividend_i); b = int'(divisor_i); v = b; k = 0;
          while (2*v <= a) begin v = 2*v; k++; end
          p_q <= W'(a / b); p_r <= W'(a % b);
          m_cnt <= 2*k + 2; m_busy <= 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string t;
    if (rst) begin
      chk("R1", "busy", busy, 0);   chk("R1", "done", done, 0);
      chk("R1", "quotient", quotient, 0); chk("R1", "remainder", remainder, 0);
    end else begin
      chk(op_tag == "R6" ? "R6" : "R3", "busy", busy, m_busy);
      chk(op_tag == "R5" ? "R5" : "R4", "done", done, m_done);
      if (!m_busy) begin
        t = m_done ? op_tag : "R7";
        chk(t, "quotient", quotient, m_q);
        chk(t, "remainder", remainder, m_r);
      end
      if (busy) dut_lat++;
      if (done) begin
        if (op_tag != "R5") chk("R8", "latency", dut_lat, dut_lat > 2*W ? 2*W : dut_lat);
        dut_lat = 0;
      end
    end
  end

  task automatic run_op(input int a, input int b, input bit disturb);
    @(negedge clk);
    while (m_busy || m_done) @(negedge clk);
    op_tag = (b == 0) ? "R5" : (disturb ? "R6" : "R2");
    #1; start = 1'b1; dividend_i = W'(a); divisor_i = W'(b);
    @(negedge clk); #1; start = 1'b0;
    if (disturb) begin
      @(negedge clk); #1; start = 1'b1; dividend_i = W'(~a); divisor_i = W'(3);
      @(negedge clk); #1; start = 1'b1; divisor_i = '0;
      @(negedge clk); #1; start = 1'b0;
    end
    while (m_busy || m_done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; rst = 1'b0;
    run_op(MAXV, 1, 0);
    run_op(0, 1, 0);
    run_op(5, 9, 0);
    run_op(MAXV, MAXV, 0);
    run_op(MAXV - 1, MAXV, 0);
    run_op(128, 2, 0);
    run_op(64, 64, 0);
    run_op(200, 7, 0);
    run_op(77, 0, 0);
    run_op(0, 0, 0);
    run_op(MAXV, 1, 1);
    run_op(250, 3, 1);
    run_op(1, 1, 0);
    for (int i = 0; i < 400; i++)
      run_op(int'($urandom_range(0, MAXV)), int'($urandom_range(0, MAXV)), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule